// File: doc/BRIEF.md
# Coherence Directory Home Controller

This block is the home-side controller for one slice of a shared cache in a directory-based coherence scheme. Every line whose address maps to this slice is tracked here by a directory entry. The entry holds a bit-vector with one bit per core that has a copy of the line, and a flag that marks the line as exclusively owned and possibly modified. Requesting cores send read or write requests for a 64-byte line, identified by its line index. The controller looks the line up, probes only the cores that must give up or downgrade their copy, counts their acknowledgements, replies to the requester, and then updates the entry.

A write to a line that other cores hold sends an invalidate probe to each of those holders, one at a time in ascending core order. A read of a line owned by another core sends a single downgrade probe to the owner. When no other core has to act, no probe is sent and the reply follows at once. The controller handles one transaction at a time. A new request, including one for the same line, is held off until the current reply has been accepted. Requests, probes, acknowledgements and replies each use a valid/ready handshake.

Top module: `coh_home_ctrl`

## Requirements
- R1: After reset, reqReady is 1 while probeValid, ackReady and replyValid are 0, and every directory entry is empty, so the first request to any line sends no probe.
- R2: A request that needs no probe gets a reply in the cycle after it is accepted. The reply carries the requester's core ID, command (0 = read, 1 = write) and line index.
- R3: An accepted read adds the requester's bit to the line's sharer vector. A later write by another core therefore probes that reader.
- R4: A write probes exactly the recorded holders other than the requester, with probeKind 0 (invalidate). Probes go out one per probe handshake, in ascending core-ID order, and each carries the request's line index.
- R5: A probing transaction replies only after it has received as many acknowledgements as probes it issued. replyValid stays 0 while any acknowledgement is missing.
- R6: After a write reply is accepted, the entry holds only the writer, marked as owner. Another core's write then probes only the writer, and a repeat write by the writer needs no probe.
- R7: A read of a line owned by a different core sends one probe with probeKind 1 (downgrade) to the owner and waits for its acknowledgement. Afterwards both cores are recorded as non-owning sharers.
- R8: From the cycle after a request is accepted until its reply handshake, reqReady is 0. A request held pending in that time is accepted afterwards and served with the updated directory.
- R9: A probe or reply that is not accepted stays valid with unchanged fields until it is accepted.
- R10: Directory entries for different line indices are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller can take a request |
| reqCore | input | CORE_W | Requesting core ID |
| reqCmd | input | 1 | 0 = read, 1 = write |
| reqLine | input | LINE_W | Line index within this slice |
| probeValid | output | 1 | Probe valid |
| probeReady | input | 1 | Probe accepted by the network |
| probeCore | output | CORE_W | Core targeted by the probe |
| probeKind | output | 1 | 0 = invalidate, 1 = downgrade |
| probeLine | output | LINE_W | Line index being probed |
| ackValid | input | 1 | Probe acknowledgement valid |
| ackReady | output | 1 | Controller awaits acknowledgements |
| replyValid | output | 1 | Reply valid |
| replyReady | input | 1 | Reply accepted by the requester |
| replyCore | output | CORE_W | Core the reply is for |
| replyCmd | output | 1 | Command being completed |
| replyLine | output | LINE_W | Line index completed |

## Verification
The directory is driven through one line's life in several patterns. Reads by several cores with no owner must finish with no probe. A write to a line with two readers must invalidate exactly those two, lowest ID first. Writes by the owner and by a new writer must show that the entry was cut down to the single writer. A read of an owned line must downgrade the owner and leave two sharers, which a later write exposes by probing both. A separate scenario holds the probe and reply channels stalled while a second request waits, which separates correct hold-and-queue behaviour from lost or early handshakes. A request to a second line shows whether the entries are independent.

// File: rtl/homedir_pkg.sv
package homedir_pkg;

  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } cmd_e;

  typedef enum logic {
    PRB_INVAL     = 1'b0,
    PRB_DOWNGRADE = 1'b1
  } probe_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_REPLY = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic probeSent;
    logic ackTaken;
    logic commitDir;
  } dpCtl_t;

endpackage

// File: rtl/homedir_dp.sv
module homedir_dp
  import homedir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W  = $clog2(NUM_CORES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CORE_W-1:0] inCore,
  input  logic              inCmd,
  input  logic [LINE_W-1:0] inLine,
  output logic              needProbe,
  output logic              pendEmpty,
  output logic              ackZero,
  output logic [CORE_W-1:0] tgtCore,
  output logic              tgtKind,
  output logic [CORE_W-1:0] curCore,
  output logic              curCmd,
  output logic [LINE_W-1:0] curLine
);

  logic [NUM_LINES-1:0][NUM_CORES-1:0] dirShr;
  logic [NUM_LINES-1:0]                dirOwned;

  logic [NUM_CORES-1:0] inBit, inShr, inTargets;
  logic                 inOwned;
  logic [NUM_CORES-1:0] pendVec, snapShr, curBit;
  logic                 snapOwned;
  logic [CNT_W-1:0]     ackCnt, inCount;
  logic [NUM_CORES-1:0] newShr;
  logic                 newOwned;

  // lookup for the incoming request
  always_comb begin
    inBit   = '0;
    inBit[inCore] = 1'b1;
    inShr   = dirShr[inLine];
    inOwned = dirOwned[inLine];
    if (inCmd == CMD_WRITE)
      inTargets = inShr & ~inBit;
    else if (inOwned)
      inTargets = inShr & ~inBit;
    else
      inTargets = '0;
    inCount = '0;
    for (int i = 0; i < NUM_CORES; i++)
      inCount = inCount + CNT_W'(inTargets[i]);
  end

  assign needProbe = |inTargets;

  // transaction registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCore   <= '0;
      curCmd    <= 1'b0;
      curLine   <= '0;
      pendVec   <= '0;
      ackCnt    <= '0;
      snapShr   <= '0;
      snapOwned <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        curCore   <= inCore;
        curCmd    <= inCmd;
        curLine   <= inLine;
        pendVec   <= inTargets;
        ackCnt    <= inCount;
        snapShr   <= inShr;
        snapOwned <= inOwned;
      end else begin
        if (ctl.probeSent) pendVec[tgtCore] <= 1'b0;
        if (ctl.ackTaken)  ackCnt <= ackCnt - 1'b1;
      end
    end
  end

  // lowest pending core is probed first
  always_comb begin
    tgtCore = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--)
      if (pendVec[i]) tgtCore = CORE_W'(i);
  end

  assign pendEmpty = (pendVec == '0);
  assign ackZero   = (ackCnt == '0);
  assign tgtKind   = (curCmd == CMD_WRITE) ? PRB_INVAL : PRB_DOWNGRADE;

  // directory update at commit
  always_comb begin
    curBit = '0;
    curBit[curCore] = 1'b1;
    if (curCmd == CMD_WRITE) begin
      newShr   = curBit;
      newOwned = 1'b1;
    end else begin
      newShr   = snapShr | curBit;
      newOwned = snapOwned && (snapShr == curBit);
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dirShr[g]   <= '0;
          dirOwned[g] <= 1'b0;
        end else if (ctl.commitDir && curLine == LINE_W'(g)) begin
          dirShr[g]   <= newShr;
          dirOwned[g] <= newOwned;
        end
      end
    end
  endgenerate

  // R4: each issued probe retires exactly one pending target
  a_r4_pend_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.probeSent && !ctl.loadReq) |=> ($countones(pendVec) == $countones($past(pendVec)) - 1));

  // R5: an acknowledgement is never taken with nothing outstanding
  a_r5_ack_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ackTaken |-> (ackCnt != '0));

  // R6: a committed write leaves the writer as sole owner
  a_r6_sole_owner: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commitDir && curCmd == CMD_WRITE) |=>
      (dirShr[curLine] == curBit && dirOwned[curLine]));

endmodule

// File: rtl/homedir_ctrl.sv
module homedir_ctrl
  import homedir_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   probeReady,
  input  logic   ackValid,
  input  logic   replyReady,
  input  logic   needProbe,
  input  logic   pendEmpty,
  input  logic   ackZero,
  output logic   reqReady,
  output logic   probeValid,
  output logic   ackReady,
  output logic   replyValid,
  output dpCtl_t ctl
);

  state_e state, stateNext;

  assign reqReady   = (state == ST_IDLE);
  assign probeValid = (state == ST_PROBE) && !pendEmpty;
  assign ackReady   = (state == ST_PROBE) && !ackZero;
  assign replyValid = (state == ST_REPLY);

  always_comb begin
    ctl.loadReq   = reqValid && reqReady;
    ctl.probeSent = probeValid && probeReady;
    ctl.ackTaken  = ackValid && ackReady;
    ctl.commitDir = replyValid && replyReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (ctl.loadReq) stateNext = needProbe ? ST_PROBE : ST_REPLY;
      ST_PROBE: if (pendEmpty && ackZero) stateNext = ST_REPLY;
      ST_REPLY: if (replyReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: no second request is taken right behind an accepted one
  a_r8_single_txn: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5: the reply waits for all probes and acknowledgements
  a_r5_reply_after_acks: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |-> (pendEmpty && ackZero));

  // R9: an unaccepted reply stays up
  a_r9_reply_hold: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && !replyReady) |=> replyValid);

endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl
  import homedir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CORE_W-1:0] reqCore,
  input  logic              reqCmd,
  input  logic [LINE_W-1:0] reqLine,
  output logic              probeValid,
  input  logic              probeReady,
  output logic [CORE_W-1:0] probeCore,
  output logic              probeKind,
  output logic [LINE_W-1:0] probeLine,
  input  logic              ackValid,
  output logic              ackReady,
  output logic              replyValid,
  input  logic              replyReady,
  output logic [CORE_W-1:0] replyCore,
  output logic              replyCmd,
  output logic [LINE_W-1:0] replyLine
);

  dpCtl_t            ctl;
  logic              needProbe, pendEmpty, ackZero;
  logic [CORE_W-1:0] curCore;
  logic              curCmd;
  logic [LINE_W-1:0] curLine;

  homedir_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .probeReady (probeReady),
    .ackValid   (ackValid),
    .replyReady (replyReady),
    .needProbe  (needProbe),
    .pendEmpty  (pendEmpty),
    .ackZero    (ackZero),
    .reqReady   (reqReady),
    .probeValid (probeValid),
    .ackReady   (ackReady),
    .replyValid (replyValid),
    .ctl        (ctl)
  );

  homedir_dp #(
    .NUM_CORES (NUM_CORES),
    .NUM_LINES (NUM_LINES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inCore    (reqCore),
    .inCmd     (reqCmd),
    .inLine    (reqLine),
    .needProbe (needProbe),
    .pendEmpty (pendEmpty),
    .ackZero   (ackZero),
    .tgtCore   (probeCore),
    .tgtKind   (probeKind),
    .curCore   (curCore),
    .curCmd    (curCmd),
    .curLine   (curLine)
  );

  assign probeLine = curLine;
  assign replyCore = curCore;
  assign replyCmd  = curCmd;
  assign replyLine = curLine;

  // R9: an unaccepted probe keeps its target and kind
  a_r9_probe_hold: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && !probeReady) |=> (probeValid && $stable(probeCore) && $stable(probeKind)));

  // R9: reply fields do not move while the reply waits
  a_r9_reply_fields: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && !replyReady) |=> ($stable(replyCore) && $stable(replyLine) && $stable(replyCmd)));

endmodule

// File: tb/coh_home_ctrl_tb.sv
module coh_home_ctrl_tb;

  localparam int NC = 4;
  localparam int NL = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqReady;
  logic [1:0] reqCore = '0;
  logic       reqCmd = 1'b0;
  logic [3:0] reqLine = '0;
  logic       probeValid, probeReady = 1'b1, probeKind;
  logic [1:0] probeCore;
  logic [3:0] probeLine;
  logic       ackValid = 1'b0, ackReady;
  logic       replyValid, replyReady = 1'b1, replyCmd;
  logic [1:0] replyCore;
  logic [3:0] replyLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  coh_home_ctrl #(.NUM_CORES(NC), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqCore(reqCore), .reqCmd(reqCmd), .reqLine(reqLine),
    .probeValid(probeValid), .probeReady(probeReady), .probeCore(probeCore),
    .probeKind(probeKind), .probeLine(probeLine),
    .ackValid(ackValid), .ackReady(ackReady),
    .replyValid(replyValid), .replyReady(replyReady), .replyCore(replyCore),
    .replyCmd(replyCmd), .replyLine(replyLine)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] m);
    for (int i = 0; i < NC; i++) if (m[i]) return i;
    return -1;
  endfunction

  // one full transaction with an expected probe set
  task automatic runTxn(input int core, input bit cmd, input int line,
                        input logic [3:0] expMask, input bit kind, input string tag);
    logic [3:0] remaining = expMask;
    int  outstanding = 0;
    int  cyc = 0;
    int  nxt;
    bit  gotReply = 1'b0;
    bit  ackLast = 1'b0;
    bit  ackRdyLast = 1'b0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqCore = core[1:0]; reqCmd = cmd; reqLine = line[3:0];
    probeReady = 1'b1; replyReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!gotReply && cyc < 60) begin
      if (ackLast && ackRdyLast) outstanding--;
      if (replyValid) begin
        chk(remaining == 0, tag, "probes missing at reply", int'(remaining), 0);
        chk(outstanding == 0, tag, "acks outstanding at reply", outstanding, 0);
        chk(replyCore == core[1:0] && replyCmd == cmd && replyLine == line[3:0],
            tag, "reply core", int'(replyCore), core);
        if (expMask == 0) chk(cyc == 0, tag, "immediate reply latency", cyc, 0);
        gotReply = 1'b1;
      end
      if (probeValid) begin
        nxt = lowest(remaining);
        chk(nxt >= 0 && int'(probeCore) == nxt, tag, "probe target", int'(probeCore), nxt);
        chk(probeKind == kind && probeLine == line[3:0], tag, "probe kind", int'(probeKind), int'(kind));
        if (nxt >= 0) remaining[nxt] = 1'b0;
        outstanding++;
      end
      ackValid = (outstanding > 0);
      ackLast = ackValid;
      ackRdyLast = ackReady;
      @(negedge clk);
      cyc++;
    end
    ackValid = 1'b0;
    chk(gotReply, tag, "reply seen", int'(gotReply), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    chk(probeValid == 1'b0, "R1", "probeValid after reset", int'(probeValid), 0);
    chk(ackReady == 1'b0, "R1", "ackReady after reset", int'(ackReady), 0);
    chk(replyValid == 1'b0, "R1", "replyValid after reset", int'(replyValid), 0);
    runTxn(0, 1'b1, 12, 4'b0000, 1'b0, "R1");
  endtask

  task automatic testReadsAndInval();
    runTxn(1, 1'b0, 5, 4'b0000, 1'b0, "R2");
    runTxn(3, 1'b0, 5, 4'b0000, 1'b0, "R2");
    runTxn(2, 1'b1, 5, 4'b1010, 1'b0, "R3");   // R4 R5: invalidate cores 1 then 3
  endtask

  task automatic testOwner();
    runTxn(1, 1'b1, 5, 4'b0100, 1'b0, "R6");
    runTxn(1, 1'b1, 5, 4'b0000, 1'b0, "R6");
  endtask

  task automatic testDowngrade();
    runTxn(0, 1'b0, 5, 4'b0010, 1'b1, "R7");
    runTxn(3, 1'b1, 5, 4'b0011, 1'b0, "R7");
  endtask

  task automatic testLines();
    runTxn(0, 1'b1, 6, 4'b0000, 1'b0, "R10");
    runTxn(1, 1'b1, 5, 4'b1000, 1'b0, "R10");
  endtask

  task automatic testHold();
    int waitCyc = 0;
    runTxn(0, 1'b0, 9, 4'b0000, 1'b0, "R8");
    runTxn(1, 1'b0, 9, 4'b0000, 1'b0, "R8");
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqCore = 2'd2; reqCmd = 1'b1; reqLine = 4'd9;
    probeReady = 1'b0;
    @(negedge clk);
    reqCore = 2'd3; reqCmd = 1'b0;                  // pending second request
    chk(probeValid && probeCore == 2'd0, "R9", "first probe", int'(probeCore), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(probeValid && probeCore == 2'd0, "R9", "stalled probe held", int'(probeCore), 0);
      chk(!reqReady, "R8", "reqReady while busy", int'(reqReady), 0);
    end
    probeReady = 1'b1;
    @(negedge clk);
    chk(probeValid && probeCore == 2'd1, "R4", "second probe", int'(probeCore), 1);
    @(negedge clk);
    chk(!probeValid, "R4", "no third probe", int'(probeValid), 0);
    ackValid = 1'b1;
    @(negedge clk);
    chk(!replyValid, "R5", "reply early after one ack", int'(replyValid), 0);
    @(negedge clk);
    ackValid = 1'b0;
    replyReady = 1'b0;
    while (!replyValid && waitCyc < 10) begin @(negedge clk); waitCyc++; end
    chk(replyValid && replyCore == 2'd2 && replyCmd, "R5", "write reply", int'(replyCore), 2);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(replyValid && replyCore == 2'd2 && replyLine == 4'd9, "R9", "stalled reply held",
          int'(replyCore), 2);
      chk(!reqReady, "R8", "reqReady while reply waits", int'(reqReady), 0);
    end
    replyReady = 1'b1;
    @(negedge clk);
    chk(reqReady, "R8", "ready after reply", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(probeValid && probeCore == 2'd2 && probeKind, "R8", "queued read downgrades writer",
        int'(probeCore), 2);
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
    waitCyc = 0;
    while (!replyValid && waitCyc < 10) begin @(negedge clk); waitCyc++; end
    chk(replyValid && replyCore == 2'd3 && !replyCmd, "R8", "queued read reply", int'(replyCore), 3);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testReadsAndInval();
    testOwner();
    testDowngrade();
    testLines();
    testHold();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule